// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog with a small write-only register port. Three registers sit behind it: a control register, a refresh register and a status register. Software writes the control register once to pick a prescaler ratio, a timeout length and the two edges of the refresh window. It then arms the watchdog with a two-write refresh sequence. The down-counter stays idle until that first sequence completes.

After arming, software must repeat the refresh sequence while the remaining count lies inside the programmed window. The watchdog raises a sticky reset request in two cases: the counter runs out, or a refresh sequence completes outside the window. Two write-one-to-clear status bits record which event caused the request.

The window edges are fractions of the full period. A start position at or below the end position gives an empty window, so every later refresh is then a violation.

Top module: `win_wdt`

## Requirements
- R1: After reset, `rst_req` is 0, `status_q` is 0, `running` is 0, `count_q` is 0 and `ctrl_q` reads 16'h3300 (divide by 1, window start 100%, window end 0%, 1024-cycle timeout).
- R2: A write to address 0 updates the control register only if it is the first control write since reset and no refresh has yet completed. Every later control write is ignored until the next reset. The fields are: prescaler select in bits 7:4, window start in bits 13:12, window end in bits 9:8 and timeout in bits 1:0. All other bits read as 0.
- R3: Timeout codes 0, 1, 2 and 3 load 1023, 4095, 8191 and 16383. The count is loaded when the first refresh completes and on every valid refresh after that.
- R4: Before the first completed refresh, `count_q` does not change, `running` stays 0 and no reset request is raised.
- R5: Prescaler code 4'b0101 decrements the counter once every 256 clocks. Every other code decrements it on every clock. A valid refresh restarts the prescaler.
- R6: A refresh is a write of 8'h00 followed by a write of 8'hFF, both to address 1, using data bits 7:0. If the write after 8'h00 carries any other value, the sequence is aborted and the count is not reloaded.
- R7: With P = reload + 1, the window start is (code+1)*P/4 and the window end is (3-code)*P/4. A refresh is valid when the count just before it satisfies end < count <= start. A valid refresh reloads the counter.
- R8: A refresh sequence that completes outside the window sets `rst_req` and status bit 1 on the same edge.
- R9: An underflow sets `rst_req` and status bit 0. With divide by 1, this happens on the P-th clock edge after the refresh edge.
- R10: `rst_req` stays high until reset. Writing 1 to a status bit at address 2 clears that bit. The counter freezes while `rst_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 refresh, 2 status |
| wr_data | input | 16 | Write data |
| ctrl_q | output | 16 | Current control register |
| count_q | output | 14 | Current down-counter value |
| running | output | 1 | Counter armed by the first refresh |
| status_q | output | 2 | Bit 0 underflow, bit 1 refresh outside window |
| rst_req | output | 1 | Sticky reset request |

## Verification
A wrong window bound or a wrong reload value shows up within one cycle of the refresh edge. The mistake appears either as `rst_req` rising or as `count_q` failing to read the reload value. The window cases are therefore driven to the exact count on each side of every edge. Faults in the prescaler or in the underflow logic only show up after a full tick period or a full timeout. The bench waits out these intervals and samples the edge of the expected change, not some later point.

// File: rtl/win_wdt_pkg.sv
package win_wdt_pkg;
  localparam int CNT_W = 14;
  localparam int PRE_W = 8;
  localparam int DW    = 16;
  localparam logic [DW-1:0] CTRL_MASK  = 16'h33F3;
  localparam logic [DW-1:0] CTRL_RESET = 16'h3300;

  function automatic logic [CNT_W-1:0] reload_of(input logic [1:0] code);
    case (code)
      2'd0:    return 14'h03FF;
      2'd1:    return 14'h0FFF;
      2'd2:    return 14'h1FFF;
      default: return 14'h3FFF;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] presc_limit(input logic [3:0] div);
    return (div == 4'b0101) ? {PRE_W{1'b1}} : '0;
  endfunction

  function automatic logic [CNT_W:0] quarter_of(input logic [CNT_W-1:0] reload);
    return ({1'b0, reload} + 1'b1) >> 2;
  endfunction

  function automatic logic [CNT_W:0] win_start(input logic [1:0] code,
                                               input logic [CNT_W-1:0] reload);
    return quarter_of(reload) * ({{(CNT_W-1){1'b0}}, code} + 1'b1);
  endfunction

  function automatic logic [CNT_W:0] win_end(input logic [1:0] code,
                                             input logic [CNT_W-1:0] reload);
    return quarter_of(reload) *
           ({{(CNT_W-1){1'b0}}, 2'd3} - {{(CNT_W-1){1'b0}}, code});
  endfunction
endpackage

// File: rtl/win_wdt_prescaler.sv
module win_wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = en && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (en)      cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/win_wdt_counter.sv
module win_wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  assign zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end
endmodule

// File: rtl/win_wdt_refresh_seq.sv
module win_wdt_refresh_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output logic       done
);
  logic armed_q;

  assign done = armed_q && wr && (data == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         armed_q <= 1'b0;
    else if (wr && armed_q)             armed_q <= 1'b0;
    else if (wr && (data == 8'h00))     armed_q <= 1'b1;
  end
endmodule

// File: rtl/win_wdt.sv
module win_wdt
  import win_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    ctrl_q,
  output logic [CNT_W-1:0] count_q,
  output logic             running,
  output logic [1:0]       status_q,
  output logic             rst_req
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RFSH = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic             cfg_written, cfg_locked, ctrl_wr;
  logic             refresh_done, refresh_ok, refresh_bad, in_window;
  logic             tick, cnt_zero, underflow_ev, count_en;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W:0]   start_pos, end_pos;

  // configuration decode
  assign reload_val = reload_of(ctrl_q[1:0]);
  assign start_pos  = win_start(ctrl_q[13:12], reload_val);
  assign end_pos    = win_end(ctrl_q[9:8], reload_val);
  assign cfg_locked = cfg_written || running;
  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL) && !cfg_locked;

  // named events
  assign in_window    = ({1'b0, count_q} <= start_pos) && ({1'b0, count_q} > end_pos);
  assign refresh_ok   = refresh_done && !rst_req && (!running || in_window);
  assign refresh_bad  = refresh_done && !rst_req && running && !in_window;
  assign count_en     = running && !rst_req;
  assign underflow_ev = tick && cnt_zero;

  win_wdt_refresh_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_en && (wr_addr == A_RFSH)),
    .data  (wr_data[7:0]),
    .done  (refresh_done)
  );

  win_wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (count_en),
    .restart (refresh_ok),
    .limit   (presc_limit(ctrl_q[7:4])),
    .tick    (tick)
  );

  win_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (refresh_ok),
    .load_val (reload_val),
    .dec      (tick),
    .count    (count_q),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_RESET;
      cfg_written <= 1'b0;
      running     <= 1'b0;
      rst_req     <= 1'b0;
      status_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q      <= wr_data & CTRL_MASK;
        cfg_written <= 1'b1;
      end
      if (refresh_ok) running <= 1'b1;
      if (underflow_ev || refresh_bad) rst_req <= 1'b1;
      status_q[0] <= underflow_ev ||
                     (status_q[0] && !(wr_en && wr_addr == A_STAT && wr_data[0]));
      status_q[1] <= refresh_bad ||
                     (status_q[1] && !(wr_en && wr_addr == A_STAT && wr_data[1]));
    end
  end
endmodule

// File: rtl/win_wdt_checker.sv
module win_wdt_checker
  import win_wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [DW-1:0]    ctrl_q,
  input logic [CNT_W-1:0] count_q,
  input logic             running,
  input logic [1:0]       status_q,
  input logic             rst_req,
  input logic             cfg_locked,
  input logic             underflow_ev,
  input logic             refresh_ok,
  input logic             refresh_bad,
  input logic [CNT_W-1:0] reload_val
);
  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && cfg_locked) |=> $stable(ctrl_q));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count_q == '0) && !rst_req);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> (count_q == $past(reload_val)) && running);

  p_window_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_bad |=> rst_req && status_q[1]);

  p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_ev |=> rst_req && status_q[0]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req && $stable(count_q));
endmodule

bind win_wdt win_wdt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .ctrl_q       (ctrl_q),
  .count_q      (count_q),
  .running      (running),
  .status_q     (status_q),
  .rst_req      (rst_req),
  .cfg_locked   (cfg_locked),
  .underflow_ev (underflow_ev),
  .refresh_ok   (refresh_ok),
  .refresh_bad  (refresh_bad),
  .reload_val   (reload_val)
);

// File: tb/tb_win_wdt.sv
module tb_win_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_q;
  logic [13:0] count_q;
  logic        running;
  logic [1:0]  status_q;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  win_wdt dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .count_q(count_q), .running(running),
    .status_q(status_q), .rst_req(rst_req)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] gap;
    logic        err;
  } vec_t;

  // second refresh sees count 1023-(gap+1); window per R7 with P=1024
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h3300, 16'd10,  1'b0},   // open window
    '{16'h1200, 16'd100, 1'b1},   // 922 above start 512
    '{16'h1200, 16'd600, 1'b0},   // 422 inside (256,512]
    '{16'h1200, 16'd510, 1'b0},   // exactly 512
    '{16'h1200, 16'd509, 1'b1},   // 513
    '{16'h1200, 16'd765, 1'b0},   // 257
    '{16'h1200, 16'd766, 1'b1},   // 256 equals end
    '{16'h2300, 16'd254, 1'b0},   // 768 equals start 75%
    '{16'h2300, 16'd253, 1'b1}    // 769
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic refresh();
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h00FF);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    do_reset();
    chk("R1 rst_req", rst_req, 0);
    chk("R1 status", status_q, 0);
    chk("R1 running", running, 0);
    chk("R1 count", count_q, 0);
    chk("R1 ctrl", ctrl_q, 16'h3300);

    // window table: R7, R8
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd0, VECS[i].ctrl);
      refresh();
      repeat (VECS[i].gap) @(negedge clk);
      refresh();
      chk("R8 rst_req", rst_req, VECS[i].err);
      chk("R8 status err", status_q[1], VECS[i].err);
      if (!VECS[i].err) chk("R7 reload", count_q, 1023);
    end

    // R2 single control write, masked fields
    do_reset();
    wr(2'd0, 16'hFFF1);
    chk("R2 masked", ctrl_q, 16'h33F1);
    wr(2'd0, 16'h3302);
    chk("R2 second write ignored", ctrl_q, 16'h33F1);
    do_reset();
    refresh();
    wr(2'd0, 16'h3303);
    chk("R2 write after refresh ignored", ctrl_q, 16'h3300);

    // R3 timeout codes
    for (int c = 0; c < 4; c++) begin
      do_reset();
      wr(2'd0, 16'h3300 | 16'(c));
      refresh();
      chk("R3 reload", count_q, (32'd1 << (c == 0 ? 10 : c + 11)) - 1);
    end

    // R4 idle before first refresh; R6 abort does not arm
    do_reset();
    wr(2'd0, 16'h3300);
    repeat (50) @(negedge clk);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0055);
    repeat (5) @(negedge clk);
    chk("R4 count idle", count_q, 0);
    chk("R4 not running", running, 0);
    chk("R4 no request", rst_req, 0);

    // R5 prescaler /256
    do_reset();
    wr(2'd0, 16'h3350);
    refresh();
    repeat (255) @(negedge clk);
    chk("R5 div256 hold", count_q, 1023);
    @(negedge clk);
    chk("R5 div256 step", count_q, 1022);
    // R5 other code divides by 1
    do_reset();
    wr(2'd0, 16'h3330);
    refresh();
    @(negedge clk);
    chk("R5 div1 other code", count_q, 1022);

    // R6 aborted sequence leaves count running, full sequence reloads
    do_reset();
    refresh();
    repeat (10) @(negedge clk);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0055);
    chk("R6 abort no reload", count_q, 1011);
    chk("R6 abort no error", status_q, 0);
    refresh();
    chk("R6 reload", count_q, 1023);

    // R9 underflow timing, R10 sticky and W1C
    do_reset();
    refresh();
    repeat (1023) @(negedge clk);
    chk("R9 before underflow", rst_req, 0);
    @(negedge clk);
    chk("R9 underflow request", rst_req, 1);
    chk("R9 underflow status", status_q, 2'b01);
    repeat (20) @(negedge clk);
    chk("R10 counter frozen", count_q, 14'h3FFF);
    wr(2'd2, 16'h0001);
    chk("R10 status cleared", status_q, 0);
    chk("R10 request sticky", rst_req, 1);

    // R10 W1C of refresh error bit only clears written bit
    do_reset();
    wr(2'd0, 16'h1200);
    refresh();
    refresh();
    wr(2'd2, 16'h0001);
    chk("R10 unwritten bit kept", status_q, 2'b10);
    wr(2'd2, 16'h0002);
    chk("R10 err cleared", status_q, 0);
    chk("R10 request held", rst_req, 1);

    finish_run();
  end
endmodule